// File: doc/BRIEF.md
# Successive Approximation Search Controller

This block is the digital half of a successive approximation converter. A low level on the start input, seen while the block is idle, begins a conversion. The block then runs a binary search of fixed length. On every clock it places a trial code on its output for an external DAC. One clock later it reads a single comparator bit, which reports whether the DAC output lies above the analog input. Bits are decided from the most significant downward, one per clock. The external DAC and comparator are the block's only partners.

Each decision either keeps the bit under test or clears it. In the same step the next lower bit is raised for the following trial. After as many decisions as the code has bits, the final code appears on the result output together with a done flag. Both stay put until a later conversion finishes. A start request that arrives during a conversion has no effect.

Top module: `sar_search`

## Requirements
- R1: After reset, the trial code, the result and the pointer are zero, and done and busy are low.
- R2: When start_n is low at a clock edge while busy is low, the next cycle shows busy high, done low, and a trial code with only the most significant bit set, which is half of full scale.
- R3: When above is high at the end of a trial cycle, the bit under test is 0 in the next trial code. The next lower bit is set to 1 and all higher bits are unchanged.
- R4: When above is low at the end of a trial cycle, the bit under test stays 1 and the next lower bit is set to 1.
- R5: Done rises exactly WIDTH clock edges after the edge that accepts the start. Busy is high for exactly those WIDTH cycles.
- R6: With a comparator that reports above as (trial > target), the result at done equals target for every target. The 8-bit target 8'b1011_0111 is one of the cases.
- R7: Once done is high, result, trial and done keep their values, whatever the comparator does, until a new start is accepted.
- R8: A low start_n while busy is high is ignored. The trial sequence and the completion cycle are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Start request, active low, acted on only when idle |
| above | input | 1 | Comparator: DAC output is above the analog input |
| trial | output | WIDTH | Trial code driven to the DAC |
| result | output | WIDTH | Final converted code |
| done | output | 1 | Result valid; held until the next start |
| busy | output | 1 | Conversion in progress |

## Verification
The search is run against targets of all zeros, which clears every tested bit, and all ones, which keeps every bit. These two cases separate the clear path from the keep path. The half-scale points 8'h80 and 8'h7F differ at the most significant decision and in every later one. The codes 8'hB7, 8'h55, 8'hAA and 8'h01 mix the two outcomes across neighbouring bits. At every step the trial code is compared with the expected prefix of the target plus the newly raised bit. Further runs hold start low during a conversion, and change the comparator after completion, to check that these events do not disturb the result.

// File: rtl/sar_search.sv
module sar_search #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             above,
  output logic [WIDTH-1:0] trial,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             busy
);

  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] ptr;
  logic [WIDTH-1:0] decided;
  logic [WIDTH-1:0] next_trial;
  logic             last_step;

  assign last_step  = ptr[0];
  assign decided    = above ? (trial & ~ptr) : trial;
  assign next_trial = decided | (ptr >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial  <= '0;
      ptr    <= '0;
      result <= '0;
      done   <= 1'b0;
      busy   <= 1'b0;
    end else if (!busy) begin
      if (!start_n) begin
        trial <= TOP_BIT;
        ptr   <= TOP_BIT;
        busy  <= 1'b1;
        done  <= 1'b0;
      end
    end else begin
      trial <= next_trial;
      ptr   <= ptr >> 1;
      if (last_step) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= next_trial;
      end
    end
  end

  AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_n) |=> (busy && !done && trial == TOP_BIT)); // R2

  AST_CLEAR_ON_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && above) |=> ((trial & $past(ptr)) == '0)); // R3

  AST_KEEP_ON_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !above) |=> ((trial & $past(ptr)) != '0)); // R4

  AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(ptr)); // R5

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy)); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(result)); // R7

  AST_IDLE_TRIAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start_n) |=> ($stable(trial) && done)); // R7

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy); // R8

endmodule

// File: tb/tb_sar_search.sv
module tb_sar_search;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_n = 1'b1;
  logic [W-1:0] target = '0;
  logic         above;
  logic [W-1:0] trial, result;
  logic         done, busy;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign above = (trial > target);

  sar_search #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .above(above),
    .trial(trial), .result(result), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_trial(input int tgt, input int k);
    int mask = ~((1 << (k + 1)) - 1);
    return (tgt & mask) | (1 << k);
  endfunction

  task automatic check_reset();
    chk(trial == 0, "R1 trial", int'(trial), 0);
    chk(result == 0, "R1 result", int'(result), 0);
    chk(done == 0 && busy == 0, "R1 flags", {done, busy}, 0);
  endtask

  task automatic convert(input logic [W-1:0] tgt, input bit poke);
    int cyc = 0;
    target = tgt;
    @(negedge clk) start_n = 1'b0;
    @(negedge clk) start_n = 1'b1;
    chk(busy && !done && trial == (1 << (W-1)), "R2 first trial", int'(trial), 1 << (W-1));
    for (int k = W - 1; k >= 0; k--) begin
      chk(trial == exp_trial(tgt, k), "R3/R4 trial step", int'(trial), exp_trial(tgt, k));
      chk(busy && !done, "R5 busy during search", {done, busy}, 1);
      if (poke && k == W / 2) start_n = 1'b0;
      @(negedge clk);
      start_n = 1'b1;
      cyc++;
    end
    chk(done && !busy && cyc == W, "R5 done after WIDTH cycles", cyc, W);
    chk(result == tgt, poke ? "R8 result with start mid-run" : "R6 result", int'(result), int'(tgt));
  endtask

  task automatic hold_test();
    logic [W-1:0] r0, t0;
    convert(8'h5A, 1'b0);
    r0 = result;
    t0 = trial;
    target = ~target;
    repeat (5) @(negedge clk);
    chk(result == r0, "R7 result held", int'(result), int'(r0));
    chk(trial == t0, "R7 trial held", int'(trial), int'(t0));
    chk(done && !busy, "R7 done held", {done, busy}, 2);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    convert(8'h00, 1'b0);
    convert(8'hFF, 1'b0);
    convert(8'hB7, 1'b0);
    convert(8'h80, 1'b0);
    convert(8'h7F, 1'b0);
    convert(8'h01, 1'b0);
    convert(8'h55, 1'b0);
    convert(8'hAA, 1'b0);
    convert(8'h3C, 1'b1);
    hold_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule